// File: doc/BRIEF.md
# I2C Master Command Controller

This block is an I2C bus master that carries one byte per command and takes its commands from a plain parallel interface. A command is a 7-bit target address, a direction bit and, for a write, one data byte. While the controller is idle, a high `ena` starts a transaction. The controller then produces START, the address frame, the data byte and the acknowledge bits. At fixed decision points it samples `ena` again. A further command to the same target in the same direction continues the transfer with no new START. A command to a different target or in the other direction gets a repeated START and a fresh address frame. A low `ena` at a decision point ends the transaction with STOP.

The bus pins are open-drain style. The block outputs pull-down enables for SCL and SDA and reads the resolved SDA level through `sda_in`. The pads and pull-ups sit outside the block. SCL comes from a fixed divider. Each bit period is four quarters of `QTR_DIV` clocks: SCL is low in quarters 0 and 1 and released in quarters 2 and 3. The command interface has no valid/ready handshake and no back-pressure. The caller holds the next command on the inputs until the decision point, and the timing of that point is fixed by the divider.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset both pull-down enables are 0, `busy` is 0, `ack_err` is 0 and `rdata` is 0.
- R2: In idle, `ena` high at a clock edge latches `addr`, `rw` and `wdata` and sets `busy` from the next cycle. A START bit follows: SCL is pulled low in quarter 0 and released in quarters 1 to 3. SDA is pulled low from quarter 2 on, so two quarters pass between SDA falling and SCL falling.
- R3: The address frame sends the 7 address bits MSB first, then the direction bit (1 = read, 0 = write). SDA is pulled low for a 0 bit. SDA changes only at the start of quarter 0 and is held while SCL is released.
- R4: In the acknowledge bit after the address, SDA is released. It is sampled at the end of quarter 2; a high level sets `ack_err`.
- R5: Data bytes go MSB first. On a write the master drives the bits as in R3. On a read SDA is released and each bit is sampled at the end of quarter 2.
- R6: After a written byte, SDA is released for one acknowledge bit. A high sample sets `ack_err`.
- R7: After a read byte the master pulls SDA low for the acknowledge bit only if the next command has the same address and is a read. Otherwise it leaves SDA released (not-acknowledge).
- R8: The decision point is the end of a written byte's acknowledge bit, or the end of a read byte's last data bit. If `ena` is high there, the command on the inputs is latched. When address and direction both match it is served with no START; otherwise a repeated START and its address frame come first. With `ena` low there, STOP follows: SCL and SDA are pulled low in quarter 0, SCL is released in quarter 1, SDA is released in quarter 2, and the block goes idle.
- R9: `busy` stays high from acceptance to the end of STOP and is low in idle. `rdata` takes the read byte at the end of its last bit and holds it while idle.
- R10: `ack_err` holds once set until the next transaction is accepted, where it clears.
- R11: Every quarter of a bit period lasts exactly `QTR_DIV` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ena | input | 1 | Start or continue a transaction |
| addr | input | ADDR_W | Target address of the command |
| rw | input | 1 | Direction: 1 read, 0 write |
| wdata | input | DATA_W | Byte to send on a write |
| rdata | output | DATA_W | Last byte received |
| busy | output | 1 | Transaction in progress |
| ack_err | output | 1 | Sticky missing-acknowledge flag |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Resolved SDA level |

## Verification
The line outputs come from registered state and phase through logic only. They therefore change in the clock after the edge that ends a quarter, and stay constant for that quarter's `QTR_DIV` clocks. The bench builds the expected level of both lines, `busy` and its own slave drive quarter by quarter. It then compares every clock at the falling edge, which is mid-cycle. Inputs for the next command change in that same mid-cycle slot, so they are settled well before the decision edge. `ack_err`, `busy` and `rdata` are checked one clock after the last STOP quarter, and the clearing of `ack_err` is checked in the first clock after acceptance.

// File: rtl/i2c_pkg.sv
package i2c_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_ADDR, ST_AACK, ST_WR,
    ST_WACK, ST_RD, ST_MACK, ST_STOP
  } state_e;
endpackage

// File: rtl/i2c_qtick.sv
module i2c_qtick #(
  parameter int QTR_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  output logic       tick,
  output logic [1:0] q
);
  localparam int CW = (QTR_DIV > 1) ? $clog2(QTR_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      q   <= '0;
    end else if (!run) begin
      cnt <= '0;
      q   <= '0;
    end else if (tick) begin
      cnt <= '0;
      q   <= q + 2'd1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_line_drv.sv
module i2c_line_drv import i2c_pkg::*; (
  input  state_e     st,
  input  logic [1:0] q,
  input  logic       tx_bit,
  input  logic       mack,
  output logic       scl_low,
  output logic       sda_low
);
  always_comb begin
    scl_low = 1'b0;
    sda_low = 1'b0;
    case (st)
      ST_START: begin
        scl_low = (q == 2'd0);
        sda_low = q[1];
      end
      ST_ADDR, ST_WR: begin
        scl_low = !q[1];
        sda_low = !tx_bit;
      end
      ST_AACK, ST_WACK, ST_RD: scl_low = !q[1];
      ST_MACK: begin
        scl_low = !q[1];
        sda_low = mack;
      end
      ST_STOP: begin
        scl_low = (q == 2'd0);
        sda_low = !q[1];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master import i2c_pkg::*; #(
  parameter int QTR_DIV = 4,
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ena,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rw,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              busy,
  output logic              ack_err,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  input  logic              sda_in
);
  localparam int SH_W = (ADDR_W + 1 > DATA_W) ? ADDR_W + 1 : DATA_W;
  localparam int BC_W = $clog2(SH_W);
  localparam logic [BC_W-1:0] ADDR_LAST = BC_W'(ADDR_W);
  localparam logic [BC_W-1:0] DATA_LAST = BC_W'(DATA_W - 1);

  state_e            state;
  logic [1:0]        q;
  logic              tick, run, sample, bit_end, same_cmd;
  logic [SH_W-1:0]   shreg;
  logic [BC_W-1:0]   bitn;
  logic [ADDR_W-1:0] addr_q;
  logic              rw_q, smp, more, pend;
  logic [DATA_W-1:0] wdata_q;

  assign run      = (state != ST_IDLE);
  assign sample   = tick && (q == 2'd2);
  assign bit_end  = tick && (q == 2'd3);
  assign same_cmd = (addr == addr_q) && (rw == rw_q);

  i2c_qtick #(.QTR_DIV(QTR_DIV)) u_qtick (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .q(q)
  );

  i2c_line_drv u_line (
    .st(state), .q(q), .tx_bit(shreg[SH_W-1]), .mack(more),
    .scl_low(scl_drive_low), .sda_low(sda_drive_low)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      shreg   <= '0;
      bitn    <= '0;
      addr_q  <= '0;
      rw_q    <= 1'b0;
      wdata_q <= '0;
      rdata   <= '0;
      busy    <= 1'b0;
      ack_err <= 1'b0;
      smp     <= 1'b1;
      more    <= 1'b0;
      pend    <= 1'b0;
    end else begin
      if (sample) smp <= sda_in;
      case (state)
        ST_IDLE: if (ena) begin
          addr_q  <= addr;
          rw_q    <= rw;
          wdata_q <= wdata;
          ack_err <= 1'b0;
          busy    <= 1'b1;
          state   <= ST_START;
        end
        ST_START: if (bit_end) begin
          shreg <= SH_W'({addr_q, rw_q}) << (SH_W - ADDR_W - 1);
          bitn  <= ADDR_LAST;
          state <= ST_ADDR;
        end
        ST_ADDR, ST_WR: if (bit_end) begin
          if (bitn == '0) begin
            state <= (state == ST_ADDR) ? ST_AACK : ST_WACK;
          end else begin
            bitn  <= bitn - 1'b1;
            shreg <= shreg << 1;
          end
        end
        ST_AACK: if (bit_end) begin
          if (smp) ack_err <= 1'b1;
          bitn <= DATA_LAST;
          if (rw_q) begin
            state <= ST_RD;
          end else begin
            shreg <= SH_W'(wdata_q) << (SH_W - DATA_W);
            state <= ST_WR;
          end
        end
        ST_WACK: if (bit_end) begin
          if (smp) ack_err <= 1'b1;
          if (ena) begin
            addr_q  <= addr;
            rw_q    <= rw;
            wdata_q <= wdata;
            if (same_cmd) begin
              shreg <= SH_W'(wdata) << (SH_W - DATA_W);
              bitn  <= DATA_LAST;
              state <= ST_WR;
            end else begin
              state <= ST_START;
            end
          end else begin
            state <= ST_STOP;
          end
        end
        ST_RD: begin
          if (sample) shreg <= {shreg[SH_W-2:0], sda_in};
          if (bit_end) begin
            if (bitn == '0) begin
              rdata <= shreg[DATA_W-1:0];
              pend  <= ena;
              more  <= ena && same_cmd;
              if (ena) begin
                addr_q  <= addr;
                rw_q    <= rw;
                wdata_q <= wdata;
              end
              state <= ST_MACK;
            end else begin
              bitn <= bitn - 1'b1;
            end
          end
        end
        ST_MACK: if (bit_end) begin
          more <= 1'b0;
          if (more) begin
            bitn  <= DATA_LAST;
            state <= ST_RD;
          end else if (pend) begin
            state <= ST_START;
          end else begin
            state <= ST_STOP;
          end
        end
        ST_STOP: if (bit_end) begin
          busy  <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

module i2c_cmd_master_chk import i2c_pkg::*; #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              ack_err,
  input logic [DATA_W-1:0] rdata,
  input logic              scl_drive_low,
  input logic              sda_drive_low,
  input state_e            st
);
  // R9
  idle_lines_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> (!scl_drive_low && !sda_drive_low));

  // R9
  idle_rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(rdata));

  // R10
  err_clear_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !ack_err);

  // R2
  start_fall_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_START && $rose(sda_drive_low)) |-> !scl_drive_low);

  // R8
  stop_rise_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STOP && $fell(sda_drive_low)) |-> !scl_drive_low);

  // R3
  sda_hold_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_START && st != ST_STOP && st == $past(st) &&
     !scl_drive_low && $past(!scl_drive_low)) |-> $stable(sda_drive_low));
endmodule

bind i2c_cmd_master i2c_cmd_master_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ack_err(ack_err), .rdata(rdata),
  .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low), .st(state)
);

// File: tb/i2c_cmd_master_tb.sv
module i2c_cmd_master_tb;
  localparam int QD   = 3;
  localparam int MAXR = 1024;
  localparam logic [6:0] SLV = 7'h52;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, ena, rw, busy, ack_err, scl_drive_low, sda_drive_low, sda_in;
  logic [6:0] addr;
  logic [7:0] wdata, rdata;
  logic       slv_low;

  assign sda_in = !(sda_drive_low || slv_low);

  i2c_cmd_master #(.QTR_DIV(QD)) u_dut (
    .clk(clk), .rst_n(rst_n), .ena(ena), .addr(addr), .rw(rw), .wdata(wdata),
    .rdata(rdata), .busy(busy), .ack_err(ack_err),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low), .sda_in(sda_in)
  );

  int tests = 0, fails = 0;
  bit done = 0;

  logic       r_scl[MAXR], r_sda[MAXR], r_slv[MAXR], r_ena[MAXR], r_rw[MAXR];
  logic [6:0] r_addr[MAXR];
  logic [7:0] r_wd[MAXR];
  string      r_tag[MAXR];
  int         nrec;

  logic       nx_ena, nx_rw;
  logic [6:0] nx_addr;
  logic [7:0] nx_wd;

  logic [6:0] c_addr[8];
  logic       c_rw[8];
  logic [7:0] c_wd[8];
  int         cn = 0, rcnt = 0;
  logic       exp_err, had_rd;
  logic [7:0] exp_rd;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic push(input logic sl, input logic dl, input logic sv, input string tag);
    r_scl[nrec] = sl; r_sda[nrec] = dl; r_slv[nrec] = sv; r_tag[nrec] = tag;
    r_ena[nrec] = nx_ena; r_addr[nrec] = nx_addr; r_rw[nrec] = nx_rw; r_wd[nrec] = nx_wd;
    nrec++;
  endtask

  // master-driven bit: SCL low in quarters 0-1, SDA pulled low for a 0
  task automatic push_out(input logic b, input string tag);
    push(1, !b, 0, tag); push(1, !b, 0, tag); push(0, !b, 0, tag); push(0, !b, 0, tag);
  endtask

  // master releases SDA; slave may pull low
  task automatic push_rel(input logic sv, input logic ml, input string tag);
    push(1, ml, sv, tag); push(1, ml, sv, tag); push(0, ml, sv, tag); push(0, ml, sv, tag);
  endtask

  task automatic add_cmd(input logic [6:0] a, input logic r, input logic [7:0] w);
    c_addr[cn] = a; c_rw[cn] = r; c_wd[cn] = w; cn++;
  endtask

  task automatic run_txn(input string name);
    nrec = 0; exp_err = 0; had_rd = 0; exp_rd = rdata;
    for (int i = 0; i < cn; i++) begin
      logic match, newf, nak, ak;
      logic [7:0] byt;
      nx_ena  = (i + 1 < cn);
      nx_addr = nx_ena ? c_addr[i+1] : 7'h00;
      nx_rw   = nx_ena ? c_rw[i+1]   : 1'b0;
      nx_wd   = nx_ena ? c_wd[i+1]   : 8'h00;
      match = (c_addr[i] == SLV);
      newf  = (i == 0) || (c_addr[i] != c_addr[i-1]) || (c_rw[i] != c_rw[i-1]);
      if (newf) begin
        push(1, 0, 0, "R2"); push(0, 0, 0, "R2"); push(0, 1, 0, "R2"); push(0, 1, 0, "R2");
        for (int b = 6; b >= 0; b--) push_out(c_addr[i][b], "R3");
        push_out(c_rw[i], "R3");
        push_rel(match, 0, "R4");
        if (!match) exp_err = 1;
      end
      if (!c_rw[i]) begin
        for (int b = 7; b >= 0; b--) push_out(c_wd[i][b], "R5");
        nak = !match || (c_wd[i] == 8'hEE);
        push_rel(!nak, 0, "R6");
        if (nak) exp_err = 1;
      end else begin
        byt = match ? (8'h5A ^ 8'(rcnt * 29)) : 8'hFF;
        rcnt++;
        for (int b = 7; b >= 0; b--) push_rel(match && !byt[b], 0, "R5");
        ak = (i + 1 < cn) && (c_addr[i+1] == c_addr[i]) && c_rw[i+1];
        push_rel(0, ak, "R7");
        exp_rd = byt; had_rd = 1;
      end
    end
    push(1, 1, 0, "R8"); push(0, 1, 0, "R8"); push(0, 0, 0, "R8"); push(0, 0, 0, "R8");

    @(negedge clk);
    ena = 1; addr = c_addr[0]; rw = c_rw[0]; wdata = c_wd[0];
    for (int r = 0; r < nrec; r++) begin
      for (int k = 0; k < QD; k++) begin
        @(negedge clk);
        ena = r_ena[r]; addr = r_addr[r]; rw = r_rw[r]; wdata = r_wd[r];
        slv_low = r_slv[r];
        if (r == 0 && k == 0) chk("R10", ack_err, 0, {name, " ack_err cleared at accept"});
        chk("R11", scl_drive_low, r_scl[r], {name, " scl per quarter"});
        chk(r_tag[r], sda_drive_low, r_sda[r], {name, " sda"});
        chk("R9", busy, 1, {name, " busy during transfer"});
      end
    end
    @(negedge clk);
    slv_low = 0; ena = 0;
    chk("R9", busy, 0, {name, " busy after stop"});
    chk("R10", ack_err, exp_err, {name, " ack_err"});
    if (had_rd) chk("R5", rdata, exp_rd, {name, " rdata"});
    repeat (4) begin
      @(negedge clk);
      chk("R8", {scl_drive_low, sda_drive_low}, 0, {name, " idle lines"});
      if (had_rd) chk("R9", rdata, exp_rd, {name, " rdata held"});
    end
    cn = 0;
  endtask

  initial begin
    rst_n = 0; ena = 0; addr = 0; rw = 0; wdata = 0; slv_low = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", {scl_drive_low, sda_drive_low, busy, ack_err}, 0, "reset outputs");
    chk("R1", rdata, 0, "reset rdata");

    add_cmd(SLV, 0, 8'h9A);                          run_txn("single write");
    add_cmd(SLV, 1, 8'h00);                          run_txn("single read");
    add_cmd(SLV, 0, 8'h11); add_cmd(SLV, 0, 8'h22);
    add_cmd(SLV, 0, 8'hEE);                          run_txn("chained writes nak");
    add_cmd(SLV, 0, 8'h33);                          run_txn("write after error");
    add_cmd(SLV, 1, 8'h00); add_cmd(SLV, 1, 8'h00);
    add_cmd(SLV, 0, 8'h44); add_cmd(7'h11, 1, 8'h00); run_txn("mixed chain");
    add_cmd(7'h11, 0, 8'h77);                        run_txn("address nak");
    add_cmd(SLV, 0, 8'hEE); add_cmd(SLV, 0, 8'h01);  run_txn("nak then ack");
    add_cmd(SLV, 1, 8'h00); add_cmd(SLV, 1, 8'h00);
    add_cmd(SLV, 1, 8'h00);                          run_txn("read burst");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule